// File: doc/BRIEF.md
# Four-Phase Capture-ID Sequencer with Double-Rate Lane Packer

This block sits behind a four-phase pipelined charge digitizer. It keeps a 2-bit capture-phase ID that steps 0, 1, 2, 3, 0 once per input clock period. Each period it accepts one digitized sample: a 6-bit mantissa, a 2-bit range exponent and a 6-bit time code. It tags the sample with the phase that was integrating when the sample was presented. Four clock periods later it drives the tagged 16-bit word onto eight output lanes, two bits per lane per period, one bit in each clock half.

The external reset input does one of two jobs, chosen by a mode input. In normal mode, a high level at a rising clock edge realigns the phase ID to 3. In charge-inject mode, the input leaves the phase ID alone. Instead, its rising edge produces a one-cycle request for a negative test charge, and its falling edge produces a one-cycle request for the opposite polarity. Because the phase tag travels with the data word, the lane output for a sample always carries the phase in which that sample was integrated.

Top module: `capid_ddr_packer`

## Requirements
- R1: With `rst_n` high and no normal-mode reset, `phase_id` advances by one modulo 4 at every rising clock edge.
- R2: While `rst_n` is low at a rising edge, `phase_id` becomes 3 and both the lanes and the pulse outputs become 0.
- R3: In normal mode (`inject_mode` = 0), a high `ext_reset` at a rising edge sets `phase_id` to 3 in the following cycle. The count resumes at 0 one edge after `ext_reset` is seen low.
- R4: In charge-inject mode (`inject_mode` = 1), `ext_reset` has no effect on `phase_id`, which keeps rotating as in R1.
- R5: In charge-inject mode, an edge that samples `ext_reset` high after it was sampled low at the previous edge makes `inj_neg_pulse` high for exactly the next cycle. `inj_neg_pulse` and `inj_pos_pulse` are never high together.
- R6: In charge-inject mode, an edge that samples `ext_reset` low after it was sampled high at the previous edge makes `inj_pos_pulse` high for exactly the next cycle.
- R7: In normal mode, an edge produces no injection pulse in the following cycle.
- R8: A sample presented during cycle n is driven on the lanes during cycle n+4. Its phase field holds the `phase_id` of cycle n. During cycles 0 to 3 after reset, the lanes read 0.
- R9: The packed word is {time code[5:0], mantissa[5:0], exponent[1:0], phase[1:0]}, with bit 0 the phase LSB. Lane i carries word bits 2i and 2i+1. This gives lane0 = phase, lane1 = exponent, lanes 2 to 4 = mantissa pairs, and lanes 5 to 7 = time-code pairs.
- R10: While `clk` is high, lane i shows word bit 2i. While `clk` is low, it shows word bit 2i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Integration clock, one phase step per period |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| ext_reset | input | 1 | Reset input: phase realign or charge-inject trigger |
| inject_mode | input | 1 | 0 = normal mode, 1 = charge-inject mode |
| mant_in | input | 6 | Sample mantissa for the current phase |
| exp_in | input | 2 | Sample range exponent |
| tdc_in | input | 6 | Sample time code |
| phase_id | output | 2 | Phase currently integrating |
| inj_neg_pulse | output | 1 | One-cycle negative charge injection request |
| inj_pos_pulse | output | 1 | One-cycle positive charge injection request |
| lanes | output | 8 | Double-rate output lanes |

## Verification
`phase_id` and both injection pulses are registered from the inputs of the previous cycle, so each is due one edge after its stimulus. The bench reads them 1 ns after that edge. A data word is due four edges after the cycle in which it was presented. The bench keeps the last eight expected words in a ring and compares cycle c against the word it stored in cycle c-4. It reads the even-bit half 1 ns after the rising edge and the odd-bit half 1 ns after the falling edge. Inputs change 2 ns after the rising edge, so no sampling point coincides with a clock edge or an input change.

// File: rtl/cap_ddr_pkg.sv
`timescale 1ns/1ps
// Package: field widths and word packing shared by the sequencer and packer.
// Assumes an even word width, so that every lane carries exactly one bit pair.
package cap_ddr_pkg;
    localparam int ID_W   = 2;
    localparam int EXP_W  = 2;
    localparam int MANT_W = 6;
    localparam int TDC_W  = 6;
    localparam int WORD_W = ID_W + EXP_W + MANT_W + TDC_W;
    localparam int LANES  = WORD_W / 2;

    typedef logic [ID_W-1:0]   phase_t;
    typedef logic [WORD_W-1:0] word_t;

    // Place the fields so that lane i receives word bits 2i and 2i+1.
    function automatic word_t pack_word(input phase_t id,
                                        input logic [EXP_W-1:0] ex,
                                        input logic [MANT_W-1:0] ma,
                                        input logic [TDC_W-1:0] td);
        return {td, ma, ex, id};
    endfunction
endpackage

// File: rtl/cap_phase_ring.sv
`timescale 1ns/1ps
// Module: cap_phase_ring
// Keeps the capture-phase counter that rotates through all 2**ID_W phases.
// Power-up reset and a realign request both force the top phase (all ones).
// Assumes the realign request is already qualified by the mode logic.
module cap_phase_ring #(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            realign,
    output logic [ID_W-1:0] phase_o
);
    localparam logic [ID_W-1:0] TOP_PHASE = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] STEP      = {{(ID_W-1){1'b0}}, 1'b1};

    logic [ID_W-1:0] phase_q;

    // Step the phase once per clock, or park it on the top phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= TOP_PHASE;
        end else if (realign) begin
            phase_q <= TOP_PHASE;
        end else begin
            phase_q <= phase_q + STEP;
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/cap_reset_ctrl.sv
`timescale 1ns/1ps
// Module: cap_reset_ctrl
// Decodes the external reset input according to the mode input.
// Normal mode: a level-sensitive realign request for the phase ring.
// Inject mode: edge detection that gives one-cycle negative and positive
// injection requests. Assumes ext_reset is already synchronous to clk.
module cap_reset_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_reset,
    input  logic inject_mode,
    output logic realign_o,
    output logic inj_neg_o,
    output logic inj_pos_o
);
    logic ext_prev_q;
    logic neg_q;
    logic pos_q;
    logic rise_w;
    logic fall_w;

    // Find the edges by comparing with the level seen at the previous edge.
    always_comb begin
        rise_w = ext_reset & ~ext_prev_q;
        fall_w = ~ext_reset & ext_prev_q;
    end

    // Keep the previous level; it is tracked in both modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_prev_q <= 1'b0;
        end else begin
            ext_prev_q <= ext_reset;
        end
    end

    // Register the injection requests; each one lasts a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q <= 1'b0;
            pos_q <= 1'b0;
        end else begin
            neg_q <= inject_mode & rise_w;
            pos_q <= inject_mode & fall_w;
        end
    end

    assign realign_o = ext_reset & ~inject_mode;
    assign inj_neg_o = neg_q;
    assign inj_pos_o = pos_q;
endmodule

// File: rtl/cap_latency_pipe.sv
`timescale 1ns/1ps
// Module: cap_latency_pipe
// A plain shift pipeline of DEPTH registers that carries the tagged words.
// Assumes DEPTH >= 1. Every stage clears to zero on reset.
module cap_latency_pipe #(
    parameter int W     = 16,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Capture the word presented this cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= din;
            end
        end else begin : g_body
            // Pass the word on by one cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/cap_ddr_lanes.sv
`timescale 1ns/1ps
// Module: cap_ddr_lanes
// Splits a word into even-bit and odd-bit half-words, registers both on the
// rising edge, and selects between them by clock level. The even half is
// driven while clk is high and the odd half while clk is low. Assumes a clock
// with a duty cycle near 50%.
module cap_ddr_lanes #(
    parameter int LANES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*LANES-1:0] word_i,
    output logic [LANES-1:0]   lanes_o
);
    logic [LANES-1:0] even_d;
    logic [LANES-1:0] odd_d;
    logic [LANES-1:0] even_q;
    logic [LANES-1:0] odd_q;

    for (genvar i = 0; i < LANES; i++) begin : g_split
        assign even_d[i] = word_i[2*i];
        assign odd_d[i]  = word_i[2*i+1];
    end

    // Hold both halves of the word for the whole clock period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            even_q <= '0;
            odd_q  <= '0;
        end else begin
            even_q <= even_d;
            odd_q  <= odd_d;
        end
    end

    // Select the half that belongs to the current clock half.
    always_comb begin
        lanes_o = clk ? even_q : odd_q;
    end
endmodule

// File: rtl/capid_ddr_packer.sv
`timescale 1ns/1ps
// Module: capid_ddr_packer (top)
// Rotates the capture-phase ID and decodes the two-mode reset input. Each
// sample is tagged with the phase integrating when it was presented. The
// tagged word is delayed so that it reaches the double-rate lanes LATENCY
// cycles later. Assumes LATENCY >= 2: one register lives in the lane stage.
module capid_ddr_packer
    import cap_ddr_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_reset,
    input  logic              inject_mode,
    input  logic [MANT_W-1:0] mant_in,
    input  logic [EXP_W-1:0]  exp_in,
    input  logic [TDC_W-1:0]  tdc_in,
    output logic [ID_W-1:0]   phase_id,
    output logic              inj_neg_pulse,
    output logic              inj_pos_pulse,
    output logic [LANES-1:0]  lanes
);
    localparam int PIPE_DEPTH = LATENCY - 1;

    logic   realign_w;
    phase_t phase_w;
    word_t  tagged_w;
    word_t  delayed_w;

    cap_reset_ctrl u_rst_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_reset   (ext_reset),
        .inject_mode (inject_mode),
        .realign_o   (realign_w),
        .inj_neg_o   (inj_neg_pulse),
        .inj_pos_o   (inj_pos_pulse)
    );

    cap_phase_ring #(.ID_W(ID_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .realign (realign_w),
        .phase_o (phase_w)
    );

    // Tag the incoming sample with the phase now integrating.
    always_comb begin
        tagged_w = pack_word(phase_w, exp_in, mant_in, tdc_in);
    end

    cap_latency_pipe #(.W(WORD_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (tagged_w),
        .dout  (delayed_w)
    );

    cap_ddr_lanes #(.LANES(LANES)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (delayed_w),
        .lanes_o (lanes)
    );

    assign phase_id = phase_w;
endmodule

// File: rtl/capid_ddr_packer_chk.sv
`timescale 1ns/1ps
// Module: capid_ddr_packer_chk
// Port-level properties for the phase rotation and the injection pulses.
// Bound to the top module.
module capid_ddr_packer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_reset,
    input logic       inject_mode,
    input logic [1:0] phase_id,
    input logic       inj_neg_pulse,
    input logic       inj_pos_pulse
);
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_reset && !inject_mode) |=> phase_id == $past(phase_id) + 2'd1); // R1

    AST_REALIGN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_reset && !inject_mode) |=> phase_id == 2'd3); // R3

    AST_INJECT_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (inject_mode && ext_reset) |=> phase_id == $past(phase_id) + 2'd1); // R4

    AST_NEG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (inject_mode && $rose(ext_reset)) |=> inj_neg_pulse); // R5

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inj_neg_pulse, inj_pos_pulse})); // R5

    AST_POS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (inject_mode && $fell(ext_reset)) |=> inj_pos_pulse); // R6

    AST_NO_PULSE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !inject_mode |=> (!inj_neg_pulse && !inj_pos_pulse)); // R7
endmodule

bind capid_ddr_packer capid_ddr_packer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_reset     (ext_reset),
    .inject_mode   (inject_mode),
    .phase_id      (phase_id),
    .inj_neg_pulse (inj_neg_pulse),
    .inj_pos_pulse (inj_pos_pulse)
);

// File: tb/capid_ddr_packer_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every 14-bit sample value through the packer while mixing in
// normal-mode realigns and charge-inject edges. Expected values are computed
// from the requirements.
module capid_ddr_packer_bench;
    localparam int NCYC = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_reset = 1'b0;
    logic       inject_mode = 1'b0;
    logic [5:0] mant_in = '0;
    logic [1:0] exp_in = '0;
    logic [5:0] tdc_in = '0;
    logic [1:0] phase_id;
    logic       inj_neg_pulse;
    logic       inj_pos_pulse;
    logic [7:0] lanes;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] ring [8];
    logic [1:0]  exp_ph;
    logic        exp_neg;
    logic        exp_pos;
    logic        prev_ext;
    logic        last_inj;
    logic        last_realign;
    logic [15:0] exp_word;

    always #4 clk = ~clk;

    capid_ddr_packer u_capid_ddr_packer (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_reset     (ext_reset),
        .inject_mode   (inject_mode),
        .mant_in       (mant_in),
        .exp_in        (exp_in),
        .tdc_in        (tdc_in),
        .phase_id      (phase_id),
        .inj_neg_pulse (inj_neg_pulse),
        .inj_pos_pulse (inj_pos_pulse),
        .lanes         (lanes)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] expv,
                       input string tag, input int cyc);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cyc, act, expv);
        end
    endtask

    function automatic logic [7:0] even_bits(input logic [15:0] w);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = w[2*i];
        return r;
    endfunction

    function automatic logic [7:0] odd_bits(input logic [15:0] w);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = w[2*i+1];
        return r;
    endfunction

    initial begin
        exp_ph = 2'd3;
        exp_neg = 1'b0;
        exp_pos = 1'b0;
        prev_ext = 1'b0;
        last_inj = 1'b0;
        last_realign = 1'b0;
        for (int k = 0; k < 8; k++) ring[k] = '0;
        repeat (3) @(posedge clk);
        for (int c = 0; c < NCYC; c++) begin
            logic [13:0] d;
            logic        inj;
            logic        ext;
            // The clock is high here: sample the even half and the registered outputs.
            #1;
            exp_word = (c >= 4) ? ring[(c - 4) % 8] : 16'h0000;
            if (c == 0) begin
                chk({14'd0, phase_id}, 16'd3, "R2 phase", c);
                chk({8'd0, lanes}, 16'd0, "R2 lanes", c);
                chk({14'd0, inj_neg_pulse, inj_pos_pulse}, 16'd0, "R2 pulses", c);
            end else begin
                if (last_realign)  chk({14'd0, phase_id}, {14'd0, exp_ph}, "R3 phase", c);
                else if (last_inj) chk({14'd0, phase_id}, {14'd0, exp_ph}, "R4 phase", c);
                else               chk({14'd0, phase_id}, {14'd0, exp_ph}, "R1 phase", c);
                if (last_inj) begin
                    chk({15'd0, inj_neg_pulse}, {15'd0, exp_neg}, "R5 neg pulse", c);
                    chk({15'd0, inj_pos_pulse}, {15'd0, exp_pos}, "R6 pos pulse", c);
                end else begin
                    chk({14'd0, inj_neg_pulse, inj_pos_pulse}, 16'd0, "R7 no pulse", c);
                end
                if (c >= 4) chk({8'd0, lanes}, {8'd0, even_bits(exp_word)}, "R8 R9 even half", c);
                else        chk({8'd0, lanes}, 16'd0, "R8 empty pipe", c);
            end
            // Apply the stimulus for this cycle.
            #1;
            rst_n = 1'b1;
            d   = 14'((c * 13) & 16'h3fff);
            inj = (c >= 7000 && c < 10000);
            if (inj) ext = ((c % 11) < 4) || ((c % 29) == 20);
            else     ext = ((c % 37) == 5) || ((c % 211) >= 100 && (c % 211) < 103);
            inject_mode = inj;
            ext_reset   = ext;
            mant_in = d[5:0];
            exp_in  = d[7:6];
            tdc_in  = d[13:8];
            ring[c % 8] = {d[13:8], d[5:0], d[7:6], exp_ph};
            // The clock is low here: sample the odd half.
            #3;
            chk({8'd0, lanes}, {8'd0, odd_bits(exp_word)}, "R10 odd half", c);
            // Compute the outputs due after the next edge.
            exp_neg = inj & ext & ~prev_ext;
            exp_pos = inj & ~ext & prev_ext;
            last_inj = inj;
            last_realign = ext & ~inj;
            exp_ph = (ext && !inj) ? 2'd3 : exp_ph + 2'd1;
            prev_ext = ext;
            @(posedge clk);
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #((NCYC + 1000) * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 run stalled actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule